// File: doc/BRIEF.md
# Linked Page-Table Address Translator

This block sits between a trace-buffer writer and system memory. It turns a linear input address into a physical address. To do so it walks a chain of 4 KB translation tables held in memory. Each table maps exactly 1 MB of input space through 256 data-page pointers, entries 0 to 255. Neighbouring tables are joined by a backward link in entry 510 and a forward link in entry 511, so the tables form a doubly linked chain rather than a multi-level tree.

The walker remembers which table it last used and which 1 MB region that table covers. Sequential traffic therefore costs one entry fetch per translation. A jump to another region follows the links one table per step. Table entries are 64 bits: bits AW-1:12 hold a page address and bit 0 is the valid flag. The walker reads entries through a simple read port with valid/ready handshakes and at most one read in flight.

Software programs the block through a small register file, with a write port and a combinational read port. The mode register selects translation or pass-through. In pass-through, addresses are forwarded unchanged and no tables are read.

Top module: `pgchain_xlat`

## Requirements
- R1: After reset the block is disabled, status (offset 4, bit 0) reads 1, control (offset 0) reads 0, `req_ready`, `rsp_valid` and `mem_req_valid` are low.
- R2: The ID register (offset 5) reads the address width AW in bits 5:0 (40 by default), with all other bits zero.
- R3: The table base register (offset 2) stores only bits AW-1:12 and the input base register (offset 3) stores only bits AW-1:20. The low bits read back as zero and have no effect on translation.
- R4: While the enable bit (offset 0, bit 0) is set, writes to the mode register (offset 1, bit 0: 1 = translate, 0 = pass-through) and to both base registers are ignored.
- R5: In pass-through mode an accepted address comes back unchanged with `rsp_err` low one cycle after acceptance. No table read is issued, and the base registers have no effect.
- R6: In translate mode let off = address − input base. The data entry read is at table + 8·off[19:12] of the table covering region off>>20. The result is that entry's bits AW-1:12 joined with the address's low 12 bits.
- R7: To reach a higher region the walker reads entry 511 (table + 0xFF8), and to reach a lower region it reads entry 510 (table + 0xFF0), one table per step. A request in the region already cached needs exactly one read.
- R8: A data entry with bit 0 clear gives a response with `rsp_err` high.
- R9: A link entry with bit 0 clear ends the walk with `rsp_err` high, and the cache stays on the last table reached.
- R10: In translate mode an address below the input base gives `rsp_err` high one cycle after acceptance, with no table read.
- R11: A translation completes exactly one cycle after the read of its final entry returns, and no read is issued while another is outstanding.
- R12: Clearing enable abandons a walk in progress with no response. Status reads 0 until any outstanding read has returned and then reads 1. Enabling again restarts the walk from the table base.
- R13: `req_ready` is high only while the block is enabled and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| cfg_we | input | 1 | register write strobe |
| cfg_waddr | input | 3 | register write offset |
| cfg_wdata | input | 64 | register write data |
| cfg_raddr | input | 3 | register read offset |
| cfg_rdata | output | 64 | register read data (combinational) |
| req_valid | input | 1 | input address valid |
| req_ready | output | 1 | block accepts an address |
| req_addr | input | AW | input address |
| rsp_valid | output | 1 | one-cycle result pulse |
| rsp_addr | output | AW | translated address |
| rsp_err | output | 1 | translation error |
| mem_req_valid | output | 1 | table read request |
| mem_req_ready | input | 1 | memory accepts the read |
| mem_req_addr | output | AW | address of the 64-bit entry |
| mem_rsp_valid | input | 1 | read data valid |
| mem_rsp_data | input | 64 | entry contents |

## Verification
The bench builds a three-table chain whose last forward link is invalid and which has one hole in the middle table. It then drives requests that stay in one region, step forward, step back two tables and run off the end of the chain. For each request it counts the table reads: a walker that forgot its cached table would show extra reads, and one that moved its cache on a failed link would miss the following same-region request. A disable issued while a read is in flight must leave status low and produce no response. Re-enabling must start again from the table base, which a stale cache would betray through the read count. Further cases are writes to the bases while enabled, low junk bits in the bases, and pass-through with junk bases. A design that let any of these through would return wrong addresses.

// File: rtl/pgchain_xlat.sv
module pgchain_xlat #(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_waddr,
  input  logic [63:0]   cfg_wdata,
  input  logic [2:0]    cfg_raddr,
  output logic [63:0]   cfg_rdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_err,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [63:0]   mem_rsp_data
);
  localparam int RGW = AW - 20;
  localparam int TW  = AW - 12;
  localparam logic [2:0] A_CTRL = 3'd0, A_MODE = 3'd1, A_TBASE = 3'd2,
                         A_IBASE = 3'd3, A_STAT = 3'd4, A_ID = 3'd5;
  localparam logic [8:0] E_PREV = 9'd510, E_NEXT = 9'd511;
  localparam logic [5:0] ID_W = 6'(AW);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DRAIN} st_t;
  st_t st;

  logic en, xl;
  logic [TW-1:0]  tbase, cur_tbl;
  logic [RGW-1:0] ibase, cur_rg, tgt_rg;
  logic [7:0]     idx;
  logic [11:0]    pg_off;

  wire [AW-1:0] ib_full = {ibase, 20'b0};
  wire [AW-1:0] off     = req_addr - ib_full;
  wire          below   = req_addr < ib_full;
  wire          hit     = tgt_rg == cur_rg;
  wire          fwd     = tgt_rg > cur_rg;
  wire [8:0]    eidx    = hit ? {1'b0, idx} : (fwd ? E_NEXT : E_PREV);
  wire          ent_ok  = mem_rsp_data[0];
  wire [TW-1:0] ent_pg  = mem_rsp_data[AW-1:12];
  wire          ready_bit = st == S_IDLE;
  wire          unused_bits = ^{cfg_wdata, mem_rsp_data};

  assign mem_req_addr  = {cur_tbl, eidx, 3'b000};
  assign mem_req_valid = st == S_ISSUE;
  assign req_ready     = en && st == S_IDLE;
  wire   accept        = req_valid && req_ready;

  always_comb begin
    case (cfg_raddr)
      A_CTRL:  cfg_rdata = 64'(en);
      A_MODE:  cfg_rdata = 64'(xl);
      A_TBASE: cfg_rdata = 64'({tbase, 12'b0});
      A_IBASE: cfg_rdata = 64'(ib_full);
      A_STAT:  cfg_rdata = 64'(ready_bit);
      A_ID:    cfg_rdata = 64'(ID_W);
      default: cfg_rdata = 64'(unused_bits & 1'b0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; xl <= 1'b0; tbase <= '0; ibase <= '0;
    end else if (cfg_we) begin
      case (cfg_waddr)
        A_CTRL:  en <= cfg_wdata[0];
        A_MODE:  if (!en) xl <= cfg_wdata[0];
        A_TBASE: if (!en) tbase <= cfg_wdata[AW-1:12];
        A_IBASE: if (!en) ibase <= cfg_wdata[AW-1:20];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_addr <= '0;
      cur_tbl <= '0; cur_rg <= '0; tgt_rg <= '0; idx <= '0; pg_off <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!en) begin
        cur_tbl <= tbase;
        cur_rg  <= '0;
        case (st)
          S_ISSUE: st <= mem_req_ready ? S_DRAIN : S_IDLE;
          S_WAIT:  st <= mem_rsp_valid ? S_IDLE : S_DRAIN;
          S_DRAIN: if (mem_rsp_valid) st <= S_IDLE;
          default: ;
        endcase
      end else begin
        case (st)
          S_IDLE: if (accept) begin
            if (!xl || below) begin
              rsp_valid <= 1'b1;
              rsp_addr  <= req_addr;
              rsp_err   <= xl;
            end else begin
              tgt_rg <= off[AW-1:20];
              idx    <= off[19:12];
              pg_off <= req_addr[11:0];
              st     <= S_ISSUE;
            end
          end
          S_ISSUE: if (mem_req_ready) st <= S_WAIT;
          S_WAIT: if (mem_rsp_valid) begin
            if (hit || !ent_ok) begin
              rsp_valid <= 1'b1;
              rsp_addr  <= {ent_pg, pg_off};
              rsp_err   <= !ent_ok;
              st        <= S_IDLE;
            end else begin
              cur_tbl <= ent_pg;
              cur_rg  <= fwd ? cur_rg + RGW'(1) : cur_rg - RGW'(1);
              st      <= S_ISSUE;
            end
          end
          S_DRAIN: if (mem_rsp_valid) st <= S_IDLE;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pgchain_xlat_chk.sv
module pgchain_xlat_chk #(
  parameter int AW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          xl,
  input logic          ready_bit,
  input logic [AW-13:0] tbase,
  input logic [AW-21:0] ibase,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic [AW-1:0] rsp_addr,
  input logic          rsp_err,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_rsp_valid
);
  logic out_q;
  logic [11:0] acc_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= 1'b0; acc_low <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) out_q <= 1'b1;
      else if (mem_rsp_valid) out_q <= 1'b0;
      if (req_valid && req_ready) acc_low <= req_addr[11:0];
    end
  end

  assert_ready_needs_enable_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !req_ready);
  assert_single_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !out_q);
  assert_busy_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> !ready_bit);
  assert_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !xl) |-> ($past(req_valid && req_ready) && rsp_addr == $past(req_addr) && !rsp_err));
  assert_xl_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && xl && !rsp_err) |-> $past(mem_rsp_valid));
  assert_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> rsp_addr[11:0] == acc_low);
  assert_locked_bases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> ($stable(tbase) && $stable(ibase) && $stable(xl)));
endmodule

bind pgchain_xlat pgchain_xlat_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .xl(xl), .ready_bit(ready_bit),
  .tbase(tbase), .ibase(ibase), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_err(rsp_err),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/test_pgchain_xlat.sv
`timescale 1ns/1ps
module test_pgchain_xlat;
  localparam logic [39:0] T0 = 40'h00_4000_0000, T1 = 40'h00_4000_5000, T2 = 40'h00_4001_2000;
  localparam logic [39:0] IB = 40'h00_1230_0000;
  localparam logic [2:0] CTRL = 0, MODE = 1, TBASE = 2, IBASE = 3, STAT = 4, ID = 5;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_waddr = 0, cfg_raddr = 0; logic [63:0] cfg_wdata = 0, cfg_rdata;
  logic req_valid = 0, req_ready; logic [39:0] req_addr = 0;
  logic rsp_valid, rsp_err; logic [39:0] rsp_addr;
  logic mem_req_valid, mem_req_ready; logic [39:0] mem_req_addr;
  logic mem_rsp_valid = 0; logic [63:0] mem_rsp_data = 0;

  pgchain_xlat i_pgchain_xlat (.*);

  always #5 clk = ~clk;

  typedef struct { logic [39:0] a; bit e; bit lat; } item_t;
  item_t q[$]; string qt[$];
  int nchk = 0, nerr = 0;
  int cyc = 0, last_rsp = -10, mcount = 0, lat = 0;
  bit stall = 0;
  logic [39:0] maddr;
  logic [63:0] mem [logic [39:0]];

  assign mem_req_ready = !stall || cyc[0];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (mem_rsp_valid) last_rsp <= cyc;
    if (!rst_n) lat <= 0;
    else if (mem_req_valid && mem_req_ready) begin
      lat <= 3; maddr <= mem_req_addr; mcount <= mcount + 1;
    end else if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem.exists(maddr) ? mem[maddr] : 64'h0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        nchk++; nerr++;
        $display("FAIL R12 unexpected response: actual %h expected none", rsp_addr);
      end else begin
        item_t it; string tg;
        it = q.pop_front(); tg = qt.pop_front();
        chk(rsp_err == it.e, {tg, " error flag"}, 64'(rsp_err), 64'(it.e));
        if (!it.e) chk(rsp_addr == it.a, {tg, " address"}, 64'(rsp_addr), 64'(it.a));
        if (it.lat) chk(cyc == last_rsp + 1, {tg, " latency"}, 64'(cyc), 64'(last_rsp + 1));
      end
    end
  end

  function automatic logic [39:0] tbl(input int r);
    return r == 0 ? T0 : (r == 1 ? T1 : T2);
  endfunction
  function automatic logic [39:0] page(input int r, input int i);
    return 40'h30_0000_0000 + (40'(r) << 24) + (40'(255 - i) << 12);
  endfunction
  function automatic logic [39:0] va(input int r, input int i, input int lo);
    return IB + 40'(r) * 40'h10_0000 + 40'(i) * 40'h1000 + 40'(lo);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    cfg_we = 1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rchk(input logic [2:0] a, input logic [63:0] exp, input string tag);
    cfg_raddr = a; #1;
    chk(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic drive(input logic [39:0] a);
    bit acc;
    req_valid = 1; req_addr = a;
    for (int k = 0; k < 1000; k++) begin
      acc = req_ready;
      @(negedge clk);
      if (acc) break;
    end
    req_valid = 0;
  endtask

  task automatic send(input logic [39:0] a, input logic [39:0] exp, input bit e, input int nf, input string tag);
    item_t it; int m0;
    it.a = exp; it.e = e; it.lat = nf > 0;
    m0 = mcount;
    q.push_back(it); qt.push_back(tag);
    drive(a);
    for (int k = 0; k < 200 && q.size() != 0; k++) begin @(negedge clk); #1; end
    chk(q.size() == 0, {tag, " response seen"}, 64'(q.size()), 64'd0);
    chk(mcount - m0 == nf, {tag, " table reads"}, 64'(mcount - m0), 64'(nf));
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < 256; i++)
        if (!(r == 1 && i == 5)) mem[tbl(r) + 40'(i * 8)] = {24'b0, page(r, i)} | 64'h1;
    mem[T0 + 40'hFF8] = {24'b0, T1} | 64'h1;
    mem[T1 + 40'hFF0] = {24'b0, T0} | 64'h1;
    mem[T1 + 40'hFF8] = {24'b0, T2} | 64'h1;
    mem[T2 + 40'hFF0] = {24'b0, T1} | 64'h1;

    repeat (3) @(negedge clk);
    chk(!req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs", 64'({req_ready, rsp_valid, mem_req_valid}), 64'd0);
    chk(!req_ready, "R13 not ready in reset", 64'(req_ready), 64'd0);
    rst_n = 1;
    @(negedge clk);
    rchk(STAT, 64'd1, "R1 status ready");
    rchk(CTRL, 64'd0, "R1 control");
    rchk(ID, 64'd40, "R2 id width");
    chk(!req_ready, "R13 disabled not ready", 64'(req_ready), 64'd0);

    wr(MODE, 64'd1);
    wr(TBASE, 64'(T0) | 64'hABC);
    wr(IBASE, 64'h0_1234_5678);
    rchk(TBASE, 64'(T0), "R3 table base masked");
    rchk(IBASE, 64'(IB), "R3 input base masked");
    wr(CTRL, 64'd1);
    @(negedge clk);
    chk(req_ready, "R13 enabled idle ready", 64'(req_ready), 64'd1);

    send(va(0, 0, 0), page(0, 0), 0, 1, "R6 region0 first");
    send(va(0, 255, 12'hFFF), page(0, 255) | 40'hFFF, 0, 1, "R6 region0 last");
    wr(TBASE, 64'h0); wr(IBASE, 64'h0); wr(MODE, 64'h0);
    rchk(TBASE, 64'(T0), "R4 table base locked");
    rchk(IBASE, 64'(IB), "R4 input base locked");
    rchk(MODE, 64'd1, "R4 mode locked");
    send(va(1, 3, 12'h123), page(1, 3) | 40'h123, 0, 2, "R7 forward step");
    send(va(1, 4, 12'h456), page(1, 4) | 40'h456, 0, 1, "R7 cached region");
    stall = 1;
    send(va(2, 200, 12'h008), page(2, 200) | 40'h008, 0, 2, "R7 forward with stalls");
    send(va(0, 7, 12'h7F0), page(0, 7) | 40'h7F0, 0, 3, "R7 backward two tables");
    stall = 0;
    send(va(1, 5, 0), 40'h0, 1, 2, "R8 invalid data entry");
    send(va(3, 0, 0), 40'h0, 1, 2, "R9 invalid forward link");
    send(va(2, 1, 12'h0AB), page(2, 1) | 40'h0AB, 0, 1, "R9 cache kept on last table");
    send(IB - 40'd4, 40'h0, 1, 0, "R10 below input base");

    drive(va(0, 1, 0));
    wr(CTRL, 64'd0);
    rchk(STAT, 64'd0, "R12 status low while draining");
    chk(!req_ready, "R13 not ready while draining", 64'(req_ready), 64'd0);
    repeat (6) @(negedge clk);
    rchk(STAT, 64'd1, "R12 status back after drain");
    chk(q.size() == 0, "R12 no response for aborted walk", 64'(q.size()), 64'd0);
    wr(CTRL, 64'd1);
    send(va(0, 9, 12'h010), page(0, 9) | 40'h010, 0, 1, "R12 restart from table base");

    wr(CTRL, 64'd0);
    wr(MODE, 64'd0);
    wr(TBASE, 64'h0_DEAD_B000);
    wr(IBASE, 64'h0_7700_0000);
    wr(CTRL, 64'd1);
    send(40'h12_3456_7ABC, 40'h12_3456_7ABC, 0, 0, "R5 pass-through");
    send(40'h00_0000_0010, 40'h00_0000_0010, 0, 0, "R5 pass-through below base");

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule